// File: doc/BRIEF.md
# Shadowed Nonvolatile SRAM Controller

This block models a static memory of 2048 bytes in which each word has a backing copy in a nonvolatile shadow array. The interface is synchronous. Address, write data, chip enable, output enable and write enable behave like an ordinary SRAM. A separate nonvolatile-enable strobe stops normal access and asks for a bulk transfer between the two arrays instead.

There are two transfers. A STORE saves the working array into the shadow. A RECALL restores the working array from the shadow. It runs in two passes: it first zeroes every working word, then loads the shadow contents. A RECALL also starts by itself when reset is released, so the memory comes up holding its saved image. While either transfer runs, a busy flag is high and every host action is locked out. A one-cycle done pulse marks the end. Each transfer lasts a parameterised number of clock cycles, which stands in for the long programming time of the nonvolatile cells.

Top module: `nvs_sram`

## Requirements
- R1: By default the memory holds 2048 words of 8 bits with an 11-bit address. A write (chip_en=1, wr_en=1, nv_en=0, busy=0) stores wdata at addr in the working array, and the highest address is writable like any other.
- R2: When chip_en=1, out_en=1, wr_en=0, nv_en=0 and busy=0 at a clock edge, rvalid is 1 after that edge and rdata holds the working word at addr. In every other case rvalid is 0 after the edge.
- R3: A transfer request is chip_en=1 with nv_en=1 while busy=0. wr_en=1 selects STORE and wr_en=0 selects RECALL. Requests made while busy=1 are ignored and do not extend or restart the running transfer.
- R4: STORE copies every working word into the shadow array. Working-array writes made after the STORE has completed leave the shadow contents unchanged.
- R5: While busy=1, host reads return rvalid=0 and host writes leave the working array unchanged.
- R6: RECALL first clears every working word to zero and then loads every shadow word into it. After completion every working word equals the shadow word at the same address.
- R7: RECALL never writes the shadow array. Repeated RECALLs return the same data.
- R8: busy is 1 during reset. After reset is released a RECALL runs automatically, and no host access is accepted until it completes.
- R9: When hw_store_en=0, a STORE request is ignored: busy stays 0 and the shadow contents are unchanged. A RECALL request is still accepted.
- R10: busy rises in the cycle after the accepting edge and stays high for STORE_CYC cycles for a STORE and RECALL_CYC cycles for a RECALL. These counts are raised to at least one and two array depths respectively. done is 1 for exactly the one cycle after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the power-up RECALL |
| chip_en | input | 1 | Chip enable for host accesses and transfer requests |
| out_en | input | 1 | Output enable for reads |
| wr_en | input | 1 | Write enable; during a request, 1 = STORE and 0 = RECALL |
| nv_en | input | 1 | Nonvolatile enable; selects a transfer request instead of an access |
| hw_store_en | input | 1 | Permits STORE requests when high |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, registered |
| rvalid | output | 1 | rdata carries a read result from the previous edge |
| busy | output | 1 | A transfer is running |
| done | output | 1 | One-cycle pulse after a transfer ends |

## Verification
The assertions rely on the request decode never raising both transfer starts together. They also rely on reset being held for at least one edge before the first use, because the lockout and done-pulse checks look one cycle back. The stimulus drives every input on the falling edge and never changes one mid-cycle. It issues a reset of several cycles before any access. It deliberately sends writes, reads and requests while busy so that the lockout rules are exercised and not only assumed. The model does not know the shadow contents at power-up, so read data is compared only for words that the stimulus has set itself.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        XF_IDLE   = 2'd0,
        XF_STORE  = 2'd1,
        XF_RECALL = 2'd2
    } xfer_kind_e;

    typedef struct packed {
        logic work_we;
        logic shadow_we;
        logic zero_fill;
    } step_ctl_t;

    function automatic int unsigned clamp_len(input int unsigned req, input int unsigned floor_v);
        return (req < floor_v) ? floor_v : req;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic step_ctl_t step_decode(input xfer_kind_e kind,
                                              input int unsigned step,
                                              input int unsigned depth);
        step_ctl_t c;
        c = '0;
        case (kind)
            XF_STORE: begin
                c.shadow_we = (step < depth);
            end
            XF_RECALL: begin
                c.work_we   = (step < 2 * depth);
                c.zero_fill = (step < depth);
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/nvs_bank.sv
module nvs_bank #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/nvs_xfer_seq.sv
module nvs_xfer_seq
    import nvs_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int STORE_CYC  = 1000000,
    parameter int RECALL_CYC = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_store,
    input  logic              start_recall,
    output logic              busy,
    output logic              done,
    output xfer_kind_e        kind,
    output step_ctl_t         ctl,
    output logic [ADDR_W-1:0] idx
);
    localparam int unsigned DEPTH      = 1 << ADDR_W;
    localparam int unsigned STORE_LEN  = clamp_len(STORE_CYC, DEPTH);
    localparam int unsigned RECALL_LEN = clamp_len(RECALL_CYC, 2 * DEPTH);
    localparam int unsigned MAX_LEN    = max_u(STORE_LEN, RECALL_LEN);
    localparam int          CW         = $clog2(MAX_LEN);

    xfer_kind_e    kind_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic [CW-1:0] last_step;

    assign last_step = (kind_q == XF_STORE) ? CW'(STORE_LEN - 1) : CW'(RECALL_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= XF_RECALL;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (kind_q == XF_IDLE) begin
                cnt_q <= '0;
                if (start_store) begin
                    kind_q <= XF_STORE;
                end else if (start_recall) begin
                    kind_q <= XF_RECALL;
                end
            end else if (cnt_q == last_step) begin
                kind_q <= XF_IDLE;
                cnt_q  <= '0;
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy = (kind_q != XF_IDLE);
    assign done = done_q;
    assign kind = kind_q;
    assign ctl  = step_decode(kind_q, int'(cnt_q), DEPTH);
    // The load pass index equals the step minus DEPTH, i.e. the same low bits.
    assign idx  = cnt_q[ADDR_W-1:0];

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));                               // R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                // R10
    AST_SINGLE_START: assert property (@(posedge clk) disable iff (rst)
        !(start_store && start_recall));                                // R3
    AST_AUTO_RECALL: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (busy && kind == XF_RECALL));                    // R8

endmodule

// File: rtl/nvs_sram.sv
module nvs_sram
    import nvs_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int STORE_CYC  = 1000000,
    parameter int RECALL_CYC = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              out_en,
    input  logic              wr_en,
    input  logic              nv_en,
    input  logic              hw_store_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              busy,
    output logic              done
);
    logic              host_rd, host_wr, start_store, start_recall;
    xfer_kind_e        xf_kind;
    step_ctl_t         ctl;
    logic [ADDR_W-1:0] xf_idx;

    logic              work_we;
    logic [ADDR_W-1:0] work_addr;
    logic [DATA_W-1:0] work_wdata, work_rd, shadow_rd;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    assign host_rd      = chip_en && out_en && !wr_en && !nv_en && !busy;
    assign host_wr      = chip_en && wr_en && !nv_en && !busy;
    assign start_store  = chip_en && nv_en && wr_en && hw_store_en && !busy;
    assign start_recall = chip_en && nv_en && !wr_en && !busy;

    nvs_xfer_seq #(
        .ADDR_W    (ADDR_W),
        .STORE_CYC (STORE_CYC),
        .RECALL_CYC(RECALL_CYC)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .start_store (start_store),
        .start_recall(start_recall),
        .busy        (busy),
        .done        (done),
        .kind        (xf_kind),
        .ctl         (ctl),
        .idx         (xf_idx)
    );

    assign work_we    = host_wr || ctl.work_we;
    assign work_addr  = busy ? xf_idx : addr;
    assign work_wdata = ctl.zero_fill ? '0 : (ctl.work_we ? shadow_rd : wdata);

    nvs_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) work_i (
        .clk  (clk),
        .we   (work_we),
        .waddr(work_addr),
        .wdata(work_wdata),
        .raddr(work_addr),
        .rdata(work_rd)
    );

    nvs_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) shadow_i (
        .clk  (clk),
        .we   (ctl.shadow_we),
        .waddr(xf_idx),
        .wdata(work_rd),
        .raddr(xf_idx),
        .rdata(shadow_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= host_rd;
            if (host_rd) begin
                rdata_q <= work_rd;
            end
        end
    end

    assign rdata  = rdata_q;
    assign rvalid = rvalid_q;

    AST_LOCKOUT_READ: assert property (@(posedge clk) disable iff (rst)
        busy |=> !rvalid);                                              // R5
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> $past(chip_en && out_en && !wr_en && !nv_en));       // R2
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (xf_kind == XF_RECALL) |-> !ctl.shadow_we);                     // R7
    AST_STORE_GATED: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && xf_kind == XF_STORE) |-> $past(hw_store_en));   // R9
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(xf_kind));                    // R3

endmodule

// File: tb/nvs_sram_tb.sv
module nvs_sram_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 5;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int SC    = 40;
    localparam int RC    = 70;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chip_en = 0, out_en = 0, wr_en = 0, nv_en = 0, hw_store_en = 1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid, busy, done;

    int n_total = 0;
    int n_bad   = 0;

    nvs_sram #(.ADDR_W(AW), .DATA_W(DW), .STORE_CYC(SC), .RECALL_CYC(RC)) dut_i (
        .clk(clk), .rst(rst), .chip_en(chip_en), .out_en(out_en), .wr_en(wr_en),
        .nv_en(nv_en), .hw_store_en(hw_store_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic void check(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endfunction

    function automatic int pat1(input int i);
        return (i * 37 + 11) & 255;
    endfunction
    function automatic int pat2(input int i);
        return (i * 13 + 200) & 255;
    endfunction

    // Behavioural reference model; -1 marks a word whose value is unknown.
    int m_work [DEPTH];
    int m_shadow [DEPTH];
    bit live = 0;
    bit e_busy = 0, e_done = 0, e_rv = 0;
    int e_left = 0, e_rd = -1;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_work[i]   = -1;
            m_shadow[i] = -1;
        end
    end

    always @(posedge clk) begin
        live = 1;
        if (rst) begin
            e_busy = 1; e_left = RC; e_done = 0; e_rv = 0;
            for (int i = 0; i < DEPTH; i++) m_work[i] = m_shadow[i];
        end else if (e_busy) begin
            e_left--;
            e_rv = 0;
            e_done = (e_left == 0);
            if (e_left == 0) e_busy = 0;
        end else begin
            e_done = 0;
            e_rv = chip_en && out_en && !wr_en && !nv_en;
            if (e_rv) e_rd = m_work[addr];
            if (chip_en && wr_en && !nv_en) m_work[addr] = int'(wdata);
            if (chip_en && nv_en) begin
                if (wr_en && hw_store_en) begin
                    for (int i = 0; i < DEPTH; i++) m_shadow[i] = m_work[i];
                    e_busy = 1; e_left = SC;
                end else if (!wr_en) begin
                    for (int i = 0; i < DEPTH; i++) m_work[i] = m_shadow[i];
                    e_busy = 1; e_left = RC;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (live) begin
            check(busy == e_busy, "R10 busy vs model", int'(busy), int'(e_busy));
            check(done == e_done, "R10 done vs model", int'(done), int'(e_done));
            check(rvalid == e_rv, "R2 rvalid vs model", int'(rvalid), int'(e_rv));
            if (e_rv && rvalid && e_rd >= 0)
                check(int'(rdata) == e_rd, "R1 rdata vs model", int'(rdata), e_rd);
        end
    end

    task automatic idle();
        chip_en = 0; out_en = 0; wr_en = 0; nv_en = 0;
    endtask

    task automatic wr(input int a, input int d);
        chip_en = 1; wr_en = 1; nv_en = 0; out_en = 0; addr = AW'(a); wdata = DW'(d);
        @(negedge clk);
        idle();
    endtask

    task automatic rd(input int a, output int val, output bit vld);
        chip_en = 1; out_en = 1; wr_en = 0; nv_en = 0; addr = AW'(a);
        @(negedge clk);
        val = int'(rdata); vld = rvalid;
        idle();
    endtask

    task automatic req(input bit store);
        chip_en = 1; nv_en = 1; wr_en = store; out_en = 0;
        @(negedge clk);
        idle();
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_all(input int which, input string tag);
        int v; bit ok;
        for (int i = 0; i < DEPTH; i++) begin
            rd(i, v, ok);
            check(ok, tag, int'(ok), 1);
            check(v == ((which == 1) ? pat1(i) : pat2(i)), tag, v, (which == 1) ? pat1(i) : pat2(i));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        int n, v;
        bit ok;
        repeat (3) @(negedge clk);
        check(busy == 1'b1, "R8 busy during reset", int'(busy), 1);
        check(rvalid == 1'b0, "R2 rvalid in reset", int'(rvalid), 0);
        rst = 0;
        count_busy(n);
        check(n == RC, "R8 power-up recall length", n, RC);
        check(done == 1'b1, "R10 done after recall", int'(done), 1);

        // R1: fill and read back, including the top address
        for (int i = 0; i < DEPTH; i++) wr(i, pat1(i));
        rd(DEPTH - 1, v, ok);
        check(ok && v == pat1(DEPTH - 1), "R1 top address", v, pat1(DEPTH - 1));
        check_all(1, "R1 readback pat1");

        // R2: output enable low gives no valid read
        chip_en = 1; out_en = 0; addr = 5'd4;
        @(negedge clk);
        check(rvalid == 1'b0, "R2 out_en low", int'(rvalid), 0);
        idle();

        // STORE, then host traffic and a recall request while busy
        req(1'b1);
        check(busy == 1'b1, "R3 store accepted", int'(busy), 1);
        wr(3, 8'hAA);
        rd(3, v, ok);
        check(ok == 1'b0, "R5 read locked out", int'(ok), 0);
        req(1'b0);
        count_busy(n);
        check(n + 3 == SC, "R10 store length, R3 request ignored", n + 3, SC);
        check(done == 1'b1, "R10 done after store", int'(done), 1);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R3 no restart", int'(busy), 0);
        rd(3, v, ok);
        check(v == pat1(3), "R5 write during busy ignored", v, pat1(3));

        // R4: overwrite working array, shadow keeps pat1
        for (int i = 0; i < DEPTH; i++) wr(i, pat2(i));
        check_all(2, "R4 working holds pat2");
        req(1'b0);
        count_busy(n);
        check(n == RC, "R10 recall length", n, RC);
        check_all(1, "R6 recall restores shadow, R4 shadow unchanged");

        // R7: second recall gives the same data
        wr(7, 0);
        req(1'b0);
        count_busy(n);
        check_all(1, "R7 repeated recall");

        // R9: store disabled
        for (int i = 0; i < DEPTH; i++) wr(i, pat2(i));
        hw_store_en = 0;
        req(1'b1);
        check(busy == 1'b0, "R9 store ignored", int'(busy), 0);
        req(1'b0);
        check(busy == 1'b1, "R9 recall still accepted", int'(busy), 1);
        count_busy(n);
        check_all(1, "R9 shadow unchanged");
        hw_store_en = 1;

        // R8: reset again, automatic recall restores saved image
        for (int i = 0; i < DEPTH; i++) wr(i, pat2(i));
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        rd(0, v, ok);
        check(ok == 1'b0, "R8 no access during power-up recall", int'(ok), 0);
        count_busy(n);
        check(n == RC - 1, "R8 recall length after reset", n, RC - 1);
        check_all(1, "R8 power-up recall data");

        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule